// File: doc/BRIEF.md
# Issue-to-ALU Path with Wire-Delay Stages and Result Bypass

This block carries instructions from a single-issue wakeup/select stage to an integer ALU that sits several wire-latch stages away. An instruction presented on the issue port in a cycle has its two source registers read from the register file in that same cycle. The operand values and the control fields then travel together through `PIPE_D` latch stages. When they arrive, the ALU resolves each operand against a bank of bypass registers and executes. The result leaves on a registered result port, and `WB_LAT` cycles after execution it is written back into the register file.

The bypass bank holds the results of the last `PIPE_D + WB_LAT` execution cycles. That depth covers every result that was still in flight when the operands were read. As a result, an instruction that depends on the instruction issued one cycle earlier can issue back to back and still compute the right value, whatever the wire delay. Issue never stalls, and the block has no back-pressure.

Top module: `wdly_issue_alu`

## Requirements
- R1: Reset is synchronous and active low. In the cycle after a reset cycle, `res_valid` and `wb_valid` are 0. After reset, every register reads as 0 and no bypass entry matches.
- R2: An instruction accepted (`iss_valid` = 1) in cycle t appears on `res_valid`/`res_tag`/`res_data` in cycle t+PIPE_D+1, with `res_tag` equal to its destination tag. Results come out one per cycle, in issue order, and issue is never stalled.
- R3: The opcode encodings are: 0 loads the immediate; 1 gives a+b; 2 gives a-b; 3 gives a AND b; 4 gives a OR b; 5 gives a XOR b; 6 gives a+immediate; 7 shifts a left by the low log2(DW) bits of b. Here a and b are the values of source registers A and B, and all arithmetic wraps modulo 2^DW.
- R4: An instruction issued in the cycle directly after its producer uses that producer's result, for any PIPE_D. Long dependent chains issued every cycle produce correct values.
- R5: Each result appears on `wb_valid`/`wb_tag`/`wb_data` WB_LAT-1 cycles after it appears on the result port. Its value is held in the register file from the next cycle on.
- R6: When several in-flight results target the same register, an operand takes the one that is youngest in program order.
- R7: An operand whose producer is no longer in the bypass window takes the register file value. Any issue distance between producer and consumer gives the correct result, including the distances at the edge of the bypass window.
- R8: A cycle with `iss_valid` = 0 produces no result and no write. The other issue fields in that cycle are ignored and change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| iss_valid | input | 1 | An instruction is selected this cycle |
| iss_op | input | 3 | Opcode (encodings in R3) |
| iss_src_a | input | TAG_W | Source register A tag |
| iss_src_b | input | TAG_W | Source register B tag |
| iss_dst | input | TAG_W | Destination register tag |
| iss_imm | input | DW | Immediate value |
| res_valid | output | 1 | A result was produced in the previous cycle |
| res_tag | output | TAG_W | Destination tag of that result |
| res_data | output | DW | Result value |
| wb_valid | output | 1 | Register file write this cycle |
| wb_tag | output | TAG_W | Register being written |
| wb_data | output | DW | Value being written |

## Verification
In a single cycle, an operand can match a bypass entry for a register while a write to that same register is landing in the register file. An operand can also match two bypass entries for one register. Directed sequences provoke both cases: two back-to-back writes to one register followed by a reader, and a producer and consumer separated by every gap from zero to past the bypass depth. These run on three instances with different wire-delay and write-latency settings. The result is judged against an in-order architectural model in the bench, so a wrong pick between bypass entries, or between a bypass entry and the register file, shows up as a data mismatch.

// File: rtl/wdly_pkg.sv
// Package: shared opcode encoding for the wire-delayed issue-to-ALU path.
// Assumes single-issue, in-order delivery to one ALU.
package wdly_pkg;

    localparam int OP_W = 3;

    typedef enum logic [OP_W-1:0] {
        OP_LDI  = 3'd0,
        OP_ADD  = 3'd1,
        OP_SUB  = 3'd2,
        OP_AND  = 3'd3,
        OP_OR   = 3'd4,
        OP_XOR  = 3'd5,
        OP_ADDI = 3'd6,
        OP_SHL  = 3'd7
    } alu_op_e;

endpackage

// File: rtl/wdly_ctl_pipe.sv
// Module: wdly_ctl_pipe
// A chain of STAGES latch stages that models a long control wire. Each
// stage carries a valid bit and a W-bit payload. Assumes STAGES >= 1.
// Reset clears the valid bits and the payloads.
module wdly_ctl_pipe #(
    parameter int STAGES = 4,
    parameter int W      = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic [W-1:0] in_data,
    output logic         out_valid,
    output logic [W-1:0] out_data
);

    logic         stg_v [STAGES];
    logic [W-1:0] stg_d [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            // Capture the issued instruction at the head of the wire.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    stg_v[0] <= 1'b0;
                    stg_d[0] <= '0;
                end else begin
                    stg_v[0] <= in_valid;
                    stg_d[0] <= in_data;
                end
            end
        end else begin : g_next
            // Move the payload one latch further along the wire.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    stg_v[s] <= 1'b0;
                    stg_d[s] <= '0;
                end else begin
                    stg_v[s] <= stg_v[s-1];
                    stg_d[s] <= stg_d[s-1];
                end
            end
        end
    end

    assign out_valid = stg_v[STAGES-1];
    assign out_data  = stg_d[STAGES-1];

endmodule

// File: rtl/wdly_regfile.sv
// Module: wdly_regfile
// Register file with NRD combinational read ports and one synchronous write
// port. A write becomes visible to reads in the cycle after it.
// Reset clears every register to zero.
module wdly_regfile #(
    parameter int NREGS = 16,
    parameter int DW    = 32,
    parameter int NRD   = 2,
    localparam int TW   = $clog2(NREGS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [TW-1:0] rd_tag  [NRD],
    output logic [DW-1:0] rd_data [NRD],
    input  logic          wr_en,
    input  logic [TW-1:0] wr_tag,
    input  logic [DW-1:0] wr_data
);

    logic [DW-1:0] mem [NREGS];

    // Apply the single write port, or clear all registers on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREGS; i++) mem[i] <= '0;
        end else if (wr_en) begin
            mem[wr_tag] <= wr_data;
        end
    end

    for (genvar p = 0; p < NRD; p++) begin : g_rd
        assign rd_data[p] = mem[rd_tag[p]];
    end

endmodule

// File: rtl/wdly_bypass_net.sv
// Module: wdly_bypass_net
// Bypass registers at the ALU. Entry 0 holds the result from the previous
// cycle, and every entry moves one place older each cycle (bubbles included).
// Each lookup port returns the youngest matching entry, or its register file
// value if no entry matches. Entry 0 drives the result port and entry
// WB_TAP drives the register file write. Assumes WB_TAP < DEPTH.
module wdly_bypass_net #(
    parameter int DEPTH  = 5,
    parameter int TW     = 4,
    parameter int DW     = 32,
    parameter int NPORTS = 2,
    parameter int WB_TAP = 0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [TW-1:0] in_tag,
    input  logic [DW-1:0] in_data,
    input  logic [TW-1:0] q_tag    [NPORTS],
    input  logic [DW-1:0] q_rf     [NPORTS],
    output logic [DW-1:0] q_val    [NPORTS],
    output logic          head_valid,
    output logic [TW-1:0] head_tag,
    output logic [DW-1:0] head_data,
    output logic          tap_valid,
    output logic [TW-1:0] tap_tag,
    output logic [DW-1:0] tap_data
);

    logic          ent_v [DEPTH];
    logic [TW-1:0] ent_t [DEPTH];
    logic [DW-1:0] ent_d [DEPTH];

    // Push the new result in at entry 0 and age all older entries.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < DEPTH; k++) begin
                ent_v[k] <= 1'b0;
                ent_t[k] <= '0;
                ent_d[k] <= '0;
            end
        end else begin
            ent_v[0] <= in_valid;
            ent_t[0] <= in_tag;
            ent_d[0] <= in_data;
            for (int k = 1; k < DEPTH; k++) begin
                ent_v[k] <= ent_v[k-1];
                ent_t[k] <= ent_t[k-1];
                ent_d[k] <= ent_d[k-1];
            end
        end
    end

    for (genvar p = 0; p < NPORTS; p++) begin : g_port
        // Scan from oldest to youngest so that the youngest match wins.
        always_comb begin
            q_val[p] = q_rf[p];
            for (int k = DEPTH - 1; k >= 0; k--) begin
                if (ent_v[k] && (ent_t[k] == q_tag[p])) q_val[p] = ent_d[k];
            end
        end
    end

    assign head_valid = ent_v[0];
    assign head_tag   = ent_t[0];
    assign head_data  = ent_d[0];
    assign tap_valid  = ent_v[WB_TAP];
    assign tap_tag    = ent_t[WB_TAP];
    assign tap_data   = ent_d[WB_TAP];

endmodule

// File: rtl/wdly_alu.sv
// Module: wdly_alu
// Single-cycle integer ALU. It is purely combinational; the result is
// registered by the bypass bank at the end of the execution cycle.
module wdly_alu
    import wdly_pkg::*;
#(
    parameter int DW    = 32,
    localparam int SH_W = $clog2(DW)
) (
    input  alu_op_e       op,
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  logic [DW-1:0] imm,
    output logic [DW-1:0] y
);

    // Select the operation named by the opcode.
    always_comb begin
        unique case (op)
            OP_LDI:  y = imm;
            OP_ADD:  y = a + b;
            OP_SUB:  y = a - b;
            OP_AND:  y = a & b;
            OP_OR:   y = a | b;
            OP_XOR:  y = a ^ b;
            OP_ADDI: y = a + imm;
            OP_SHL:  y = a << b[SH_W-1:0];
            default: y = '0;
        endcase
    end

endmodule

// File: rtl/wdly_issue_alu.sv
// Module: wdly_issue_alu (top)
// The path from issue to ALU with PIPE_D wire-latch stages in between.
// Operands are read from the register file in the issue cycle and travel with
// the control fields. At the ALU they are corrected from BYP_DEPTH bypass
// registers, which span every result that can be missing from the file when
// it was read. Results are written back WB_LAT cycles after execution.
// Assumes PIPE_D >= 1, WB_LAT >= 1, one issue per cycle, and no stalls.
module wdly_issue_alu
    import wdly_pkg::*;
#(
    parameter int  PIPE_D = 4,
    parameter int  WB_LAT = 1,
    parameter int  NREGS  = 16,
    parameter int  DW     = 32,
    localparam int TAG_W  = $clog2(NREGS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             iss_valid,
    input  logic [OP_W-1:0]  iss_op,
    input  logic [TAG_W-1:0] iss_src_a,
    input  logic [TAG_W-1:0] iss_src_b,
    input  logic [TAG_W-1:0] iss_dst,
    input  logic [DW-1:0]    iss_imm,
    output logic             res_valid,
    output logic [TAG_W-1:0] res_tag,
    output logic [DW-1:0]    res_data,
    output logic             wb_valid,
    output logic [TAG_W-1:0] wb_tag,
    output logic [DW-1:0]    wb_data
);

    localparam int BYP_DEPTH = PIPE_D + WB_LAT;
    localparam int PAY_W     = OP_W + 3 * TAG_W + 3 * DW;

    // Register file read at issue.
    logic [TAG_W-1:0] rf_rd_tag  [2];
    logic [DW-1:0]    rf_rd_data [2];

    assign rf_rd_tag[0] = iss_src_a;
    assign rf_rd_tag[1] = iss_src_b;

    wdly_regfile #(.NREGS(NREGS), .DW(DW), .NRD(2)) u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_tag  (rf_rd_tag),
        .rd_data (rf_rd_data),
        .wr_en   (wb_valid),
        .wr_tag  (wb_tag),
        .wr_data (wb_data)
    );

    // Control and operands travel together across the wire stages.
    logic [PAY_W-1:0] pay_in, pay_out;
    logic             ex_valid;

    assign pay_in = {iss_op, iss_src_a, iss_src_b, iss_dst, iss_imm,
                     rf_rd_data[0], rf_rd_data[1]};

    wdly_ctl_pipe #(.STAGES(PIPE_D), .W(PAY_W)) u_wire (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (iss_valid),
        .in_data   (pay_in),
        .out_valid (ex_valid),
        .out_data  (pay_out)
    );

    // Unpack the instruction that reaches the ALU this cycle.
    logic [OP_W-1:0]  ex_op_raw;
    logic [TAG_W-1:0] ex_src_a, ex_src_b, ex_dst;
    logic [DW-1:0]    ex_imm, ex_rf_a, ex_rf_b;

    assign {ex_op_raw, ex_src_a, ex_src_b, ex_dst, ex_imm, ex_rf_a, ex_rf_b} = pay_out;

    // Operand correction through the bypass bank.
    logic [TAG_W-1:0] byp_tag [2];
    logic [DW-1:0]    byp_rf  [2];
    logic [DW-1:0]    byp_val [2];
    logic [DW-1:0]    ex_result;

    assign byp_tag[0] = ex_src_a;
    assign byp_tag[1] = ex_src_b;
    assign byp_rf[0]  = ex_rf_a;
    assign byp_rf[1]  = ex_rf_b;

    wdly_bypass_net #(
        .DEPTH  (BYP_DEPTH),
        .TW     (TAG_W),
        .DW     (DW),
        .NPORTS (2),
        .WB_TAP (WB_LAT - 1)
    ) u_byp (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (ex_valid),
        .in_tag     (ex_dst),
        .in_data    (ex_result),
        .q_tag      (byp_tag),
        .q_rf       (byp_rf),
        .q_val      (byp_val),
        .head_valid (res_valid),
        .head_tag   (res_tag),
        .head_data  (res_data),
        .tap_valid  (wb_valid),
        .tap_tag    (wb_tag),
        .tap_data   (wb_data)
    );

    wdly_alu #(.DW(DW)) u_alu (
        .op  (alu_op_e'(ex_op_raw)),
        .a   (byp_val[0]),
        .b   (byp_val[1]),
        .imm (ex_imm),
        .y   (ex_result)
    );

endmodule

// File: rtl/wdly_issue_alu_chk.sv
// Module: wdly_issue_alu_chk
// Property checker for wdly_issue_alu, attached with a bind. It keeps short
// histories of issue and result activity and compares the outputs and the
// register file against them.
module wdly_issue_alu_chk #(
    parameter int  PIPE_D = 4,
    parameter int  WB_LAT = 1,
    parameter int  NREGS  = 16,
    parameter int  DW     = 32,
    localparam int TAG_W  = $clog2(NREGS)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             iss_valid,
    input logic             res_valid,
    input logic [TAG_W-1:0] res_tag,
    input logic [DW-1:0]    res_data,
    input logic             wb_valid,
    input logic [TAG_W-1:0] wb_tag,
    input logic [DW-1:0]    wb_data,
    input logic [DW-1:0]    rf_mem [NREGS]
);

    localparam int RH_N = (WB_LAT > 1) ? WB_LAT - 1 : 1;

    logic             iss_hist [PIPE_D + 1];
    logic             rh_v [RH_N];
    logic [TAG_W-1:0] rh_t [RH_N];
    logic [DW-1:0]    rh_d [RH_N];
    logic             was_reset;
    logic             last_wv;
    logic [TAG_W-1:0] last_wt;
    logic [DW-1:0]    last_wd;

    // Record issue, result and write activity for the later comparisons.
    always_ff @(posedge clk) begin
        was_reset <= !rst_n;
        if (!rst_n) begin
            for (int k = 0; k <= PIPE_D; k++) iss_hist[k] <= 1'b0;
            for (int k = 0; k < RH_N; k++) begin
                rh_v[k] <= 1'b0;
                rh_t[k] <= '0;
                rh_d[k] <= '0;
            end
            last_wv <= 1'b0;
            last_wt <= '0;
            last_wd <= '0;
        end else begin
            iss_hist[0] <= iss_valid;
            for (int k = 1; k <= PIPE_D; k++) iss_hist[k] <= iss_hist[k-1];
            rh_v[0] <= res_valid;
            rh_t[0] <= res_tag;
            rh_d[0] <= res_data;
            for (int k = 1; k < RH_N; k++) begin
                rh_v[k] <= rh_v[k-1];
                rh_t[k] <= rh_t[k-1];
                rh_d[k] <= rh_d[k-1];
            end
            last_wv <= wb_valid;
            last_wt <= wb_tag;
            last_wd <= wb_data;
        end
    end

    // R1: outputs idle in the cycle after a reset cycle.
    always_comb begin
        if (was_reset) begin
            a_r1_reset_idle: assert (!res_valid && !wb_valid);
        end
    end

    // R2: a result appears exactly PIPE_D+1 cycles after each issue.
    a_r2_result_latency: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid == iss_hist[PIPE_D]);

    // R5: the write port repeats the result port WB_LAT-1 cycles later.
    if (WB_LAT == 1) begin : g_wb_same
        a_r5_wb_tap: assert property (@(posedge clk) disable iff (!rst_n)
            (wb_valid == res_valid) &&
            (!res_valid || (wb_tag == res_tag && wb_data == res_data)));
    end else begin : g_wb_late
        a_r5_wb_tap: assert property (@(posedge clk) disable iff (!rst_n)
            (wb_valid == rh_v[WB_LAT-2]) &&
            (!wb_valid || (wb_tag == rh_t[WB_LAT-2] && wb_data == rh_d[WB_LAT-2])));
    end

    // R5: a written value is held in the register file one cycle later.
    a_r5_rf_commit: assert property (@(posedge clk) disable iff (!rst_n)
        last_wv |-> rf_mem[last_wt] == last_wd);

endmodule

bind wdly_issue_alu wdly_issue_alu_chk #(
    .PIPE_D (PIPE_D),
    .WB_LAT (WB_LAT),
    .NREGS  (NREGS),
    .DW     (DW)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .iss_valid (iss_valid),
    .res_valid (res_valid),
    .res_tag   (res_tag),
    .res_data  (res_data),
    .wb_valid  (wb_valid),
    .wb_tag    (wb_tag),
    .wb_data   (wb_data),
    .rf_mem    (u_rf.mem)
);

// File: tb/wdly_issue_alu_bench.sv
// Bench: three instances with different wire-delay and write-latency settings
// receive the same stimulus. Expected outputs come from an in-order
// architectural model that is updated at issue time.
module wdly_issue_alu_bench;

    localparam int NI = 3;
    localparam int LD  [NI] = '{4, 1, 7};
    localparam int WBL [NI] = '{1, 3, 2};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        iss_valid = 1'b0;
    logic [2:0]  iss_op = '0;
    logic [3:0]  iss_src_a = '0, iss_src_b = '0, iss_dst = '0;
    logic [31:0] iss_imm = '0;

    logic        rv [NI];
    logic [3:0]  rt [NI];
    logic [31:0] rd [NI];
    logic        wv [NI];
    logic [3:0]  wt [NI];
    logic [31:0] wd [NI];

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit finished = 0;

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    wdly_issue_alu u_wdly_issue_alu (
        .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_op(iss_op),
        .iss_src_a(iss_src_a), .iss_src_b(iss_src_b), .iss_dst(iss_dst), .iss_imm(iss_imm),
        .res_valid(rv[0]), .res_tag(rt[0]), .res_data(rd[0]),
        .wb_valid(wv[0]), .wb_tag(wt[0]), .wb_data(wd[0]));

    wdly_issue_alu #(.PIPE_D(1), .WB_LAT(3)) u_wdly_issue_alu_d1 (
        .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_op(iss_op),
        .iss_src_a(iss_src_a), .iss_src_b(iss_src_b), .iss_dst(iss_dst), .iss_imm(iss_imm),
        .res_valid(rv[1]), .res_tag(rt[1]), .res_data(rd[1]),
        .wb_valid(wv[1]), .wb_tag(wt[1]), .wb_data(wd[1]));

    wdly_issue_alu #(.PIPE_D(7), .WB_LAT(2)) u_wdly_issue_alu_d7 (
        .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_op(iss_op),
        .iss_src_a(iss_src_a), .iss_src_b(iss_src_b), .iss_dst(iss_dst), .iss_imm(iss_imm),
        .res_valid(rv[2]), .res_tag(rt[2]), .res_data(rd[2]),
        .wb_valid(wv[2]), .wb_tag(wt[2]), .wb_data(wd[2]));

    // Expected-result rings indexed by cycle, and the architectural model.
    bit          ev  [NI][64];
    logic [3:0]  et  [NI][64];
    logic [31:0] edv [NI][64];
    string       eq  [NI][64];
    bit          wev [NI][64];
    logic [3:0]  wet [NI][64];
    logic [31:0] wed [NI][64];
    string       wq  [NI][64];
    logic [31:0] arch [16];
    string       cur_req = "R2";

    function automatic logic [31:0] alu_ref(input logic [2:0] op, input logic [31:0] a,
                                            input logic [31:0] b, input logic [31:0] imm);
        case (op)
            3'd0: return imm;
            3'd1: return a + b;
            3'd2: return a - b;
            3'd3: return a & b;
            3'd4: return a | b;
            3'd5: return a ^ b;
            3'd6: return a + imm;
            default: return a << b[4:0];
        endcase
    endfunction

    task automatic fail(input string req, input string what, input logic [31:0] act,
                        input logic [31:0] exp, input int inst);
        errors++;
        $display("FAIL %s %s inst%0d cycle %0d actual %0h expected %0h",
                 req, what, inst, cyc, act, exp);
    endtask

    // Compare every instance's outputs with the expectations for this cycle.
    task automatic check_cycle();
        int s = cyc % 64;
        for (int i = 0; i < NI; i++) begin
            checks++;
            if (rv[i] !== ev[i][s]) fail("R2", "res_valid", {31'd0, rv[i]}, {31'd0, ev[i][s]}, i);
            else if (ev[i][s] && (rt[i] !== et[i][s] || rd[i] !== edv[i][s]))
                fail(eq[i][s], "res tag/data", {rt[i], rd[i][27:0]}, {et[i][s], edv[i][s][27:0]}, i);
            checks++;
            if (wv[i] !== wev[i][s]) fail("R5", "wb_valid", {31'd0, wv[i]}, {31'd0, wev[i][s]}, i);
            else if (wev[i][s] && (wt[i] !== wet[i][s] || wd[i] !== wed[i][s]))
                fail("R5", "wb tag/data", {wt[i], wd[i][27:0]}, {wet[i][s], wed[i][s][27:0]}, i);
            ev[i][s] = 0;
            wev[i][s] = 0;
        end
    endtask

    // One cycle: check outputs, then present one issue slot and schedule it.
    task automatic step(input bit v, input logic [2:0] op, input logic [3:0] a,
                        input logic [3:0] b, input logic [3:0] d, input logic [31:0] imm);
        logic [31:0] r;
        int s;
        @(negedge clk);
        check_cycle();
        iss_valid = v; iss_op = op; iss_src_a = a; iss_src_b = b; iss_dst = d; iss_imm = imm;
        if (v) begin
            r = alu_ref(op, arch[a], arch[b], imm);
            arch[d] = r;
            for (int i = 0; i < NI; i++) begin
                s = (cyc + LD[i] + 1) % 64;
                ev[i][s] = 1; et[i][s] = d; edv[i][s] = r; eq[i][s] = cur_req;
                s = (cyc + LD[i] + WBL[i]) % 64;
                wev[i][s] = 1; wet[i][s] = d; wed[i][s] = r; wq[i][s] = cur_req;
            end
        end
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) step(0, 3'd0, 4'd0, 4'd0, 4'd0, 32'd0);
    endtask

    initial begin
        logic [3:0] last_dst = 0;
        for (int r = 0; r < 16; r++) arch[r] = 0;
        for (int i = 0; i < NI; i++)
            for (int s = 0; s < 64; s++) begin ev[i][s] = 0; wev[i][s] = 0; end
        void'($urandom(32'h5eed_1234));
        repeat (4) @(negedge clk);
        // R1: outputs idle while and after reset is held.
        for (int i = 0; i < NI; i++) begin
            checks++;
            if (rv[i] !== 1'b0 || wv[i] !== 1'b0)
                fail("R1", "outputs in reset", {30'd0, rv[i], wv[i]}, 32'd0, i);
        end
        rst_n = 1'b1;
        idle(2);

        // R1: registers read zero after reset.
        cur_req = "R1";
        step(1, 3'd1, 4'd2, 4'd3, 4'd1, 32'hffff);
        step(1, 3'd4, 4'd9, 4'd15, 4'd4, 32'd7);
        idle(12);

        // R3: each opcode on known operands.
        cur_req = "R3";
        step(1, 3'd0, 4'd0, 4'd0, 4'd1, 32'hf0f0_1234);
        step(1, 3'd0, 4'd0, 4'd0, 4'd2, 32'h0000_0003);
        idle(12);
        for (int op = 1; op < 8; op++) step(1, 3'(op), 4'd1, 4'd2, 4'd3, 32'h10);
        idle(12);

        // R4: back-to-back dependent chain issued every cycle.
        cur_req = "R4";
        step(1, 3'd0, 4'd0, 4'd0, 4'd5, 32'd100);
        for (int k = 0; k < 12; k++) step(1, 3'd6, 4'd5, 4'd0, 4'd5, 32'd3);
        step(1, 3'd1, 4'd5, 4'd5, 4'd6, 32'd0);
        idle(12);

        // R6: two writes to one register, then a reader at several distances.
        cur_req = "R6";
        for (int g = 0; g < 4; g++) begin
            step(1, 3'd0, 4'd0, 4'd0, 4'd7, 32'd7 + g);
            step(1, 3'd0, 4'd0, 4'd0, 4'd7, 32'd90 + g);
            idle(g);
            step(1, 3'd1, 4'd7, 4'd7, 4'd8, 32'd0);
            idle(12);
        end

        // R7: producer-to-consumer gaps across the bypass window edge.
        cur_req = "R7";
        for (int gap = 0; gap < 13; gap++) begin
            step(1, 3'd0, 4'd0, 4'd0, 4'd9, 32'd1000 + gap);
            idle(gap);
            step(1, 3'd6, 4'd9, 4'd0, 4'd10, 32'd1);
        end
        idle(12);

        // R8: bubbles carrying garbage fields must change nothing.
        cur_req = "R8";
        step(1, 3'd0, 4'd0, 4'd0, 4'd11, 32'h55);
        idle(12);
        for (int k = 0; k < 6; k++) step(0, 3'd0, 4'd0, 4'd0, 4'd11, 32'hdead_0000 + k);
        idle(12);
        step(1, 3'd1, 4'd11, 4'd0, 4'd12, 32'd0);
        idle(12);

        // R2 R3 R4 R6 R7: constrained random mix with frequent dependences.
        cur_req = "R3";
        for (int n = 0; n < 3000; n++) begin
            bit v = ($urandom % 100) < 85;
            logic [3:0] a = ($urandom % 2) ? last_dst : 4'($urandom);
            logic [3:0] b = ($urandom % 3 == 0) ? last_dst : 4'($urandom);
            logic [3:0] d = 4'($urandom);
            step(v, 3'($urandom), a, b, d, $urandom);
            if (v) last_dst = d;
        end
        cur_req = "R2";
        idle(16);

        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            errors++;
            checks++;
            $display("FAIL R2 watchdog expired actual %0d expected %0d", cyc, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule